// File: doc/BRIEF.md
# Quadlet CRC-16 Engine

This block computes a 16-bit check value over a stream of 32-bit words. It is meant for tables such as a topology map or a speed map, whose header carries a check over the words that follow. Each word is consumed four bits at a time, starting with the most significant nibble. A shift-and-XOR rule with terms at bit offsets 12, 5 and 0 folds each nibble into a 16-bit running value. Words arrive in bus (big-endian) order. Byte swapping from host memory happens upstream.

A caller pulses the clear input to zero the running value. It then hands over words through a valid/ready handshake and marks the final word with the last flag. The number of words presented is the length the result covers. After the final nibble of the last word, the engine pulses done and freezes the result until the next clear. The parameter `NIB_PER_CYC` (1, 2, 4 or 8) sets how many nibbles are folded per clock. The default of 1 gives a small nibble-serial engine. A value of 8 unrolls a whole word into one clock.

Top module: `crc_quad_engine`

## Requirements
- R1: After reset or a clear pulse, crc_o is 0x0000, ready_o is 1 and done_o is 0.
- R2: Starting from 0, each nibble n, taken from bits 31..28 down to 3..0, updates the value c as s = c[15:12] XOR n, then c = (c << 4) XOR (s << 12) XOR (s << 5) XOR s, kept to 16 bits. One word 0x00000001 gives 0x1021.
- R3: The result equals the update applied to exactly the words accepted since the last clear, in the order they were accepted.
- R4: A word is taken in a cycle where valid_i and ready_o are both high and clear_i is low. After that, ready_o stays low for exactly 8/NIB_PER_CYC cycles.
- R5: done_o is high for exactly one cycle, the cycle after the final step of the word taken with last_i high. crc_o holds the final result in that cycle.
- R6: After done_o, ready_o stays low and crc_o does not change until a clear, even while valid_i is held high.
- R7: A clear pulse during a calculation aborts it. A calculation started afterwards begins from zero.
- R8: When clear_i and valid_i are high in the same cycle, the word is not taken.
- R9: When clear_i is high in the cycle of the final step of a last word, no done pulse appears and crc_o reads 0x0000.
- R10: While the engine waits idle between words, crc_o keeps the value reached after the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous clear and abort |
| valid_i | input | 1 | Word on word_i is offered |
| last_i | input | 1 | Offered word is the final one |
| word_i | input | 32 | Data word, bus order |
| ready_o | output | 1 | Engine can take a word |
| crc_o | output | 16 | Running or final check value |
| done_o | output | 1 | One-cycle pulse when the result is final |

## Verification
Clear can collide with two other events: a word hand-over, and the final nibble step of the last word. The bench raises clear in the exact cycle a word is offered to an idle engine. It expects the word to be dropped, ready to stay high and the value to stay zero. It also counts the steps of a last word and raises clear during the final step. It expects no done pulse and a zero result, and it expects a following calculation to start from zero.

// File: rtl/crc_quad_pkg.sv
`timescale 1ns/1ps
package crc_quad_pkg;
  localparam int CRC_W  = 16;
  localparam int WORD_W = 32;
  localparam int NIB_W  = 4;
  localparam int NIBS   = WORD_W / NIB_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/crc_nib_step.sv
`timescale 1ns/1ps
module crc_nib_step
  import crc_quad_pkg::*;
(
  input  logic [CRC_W-1:0] chk_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [CRC_W-1:0] chk_o
);
  logic [NIB_W-1:0] sum;

  always_comb begin
    sum   = chk_i[CRC_W-1 -: NIB_W] ^ nib_i;
    chk_o = {chk_i[CRC_W-NIB_W-1:0], {NIB_W{1'b0}}}
          ^ {sum, 12'h000}
          ^ {7'h00, sum, 5'h00}
          ^ {12'h000, sum};
  end
endmodule

// File: rtl/crc_lane.sv
`timescale 1ns/1ps
module crc_lane
  import crc_quad_pkg::*;
#(
  parameter int NIB_PER_CYC = 1,
  localparam int BITS_W = NIB_PER_CYC * NIB_W
) (
  input  logic [CRC_W-1:0]  chk_i,
  input  logic [BITS_W-1:0] bits_i,
  output logic [CRC_W-1:0]  chk_o
);
  logic [CRC_W-1:0] chain [NIB_PER_CYC+1];

  assign chain[0] = chk_i;

  for (genvar g = 0; g < NIB_PER_CYC; g++) begin : g_step
    // most significant nibble goes first
    crc_nib_step u_step (
      .chk_i (chain[g]),
      .nib_i (bits_i[BITS_W-1-g*NIB_W -: NIB_W]),
      .chk_o (chain[g+1])
    );
  end

  assign chk_o = chain[NIB_PER_CYC];
endmodule

// File: rtl/crc_seq_ctrl.sv
`timescale 1ns/1ps
module crc_seq_ctrl
  import crc_quad_pkg::*;
#(
  parameter int NIB_PER_CYC = 1,
  localparam int STEPS = NIBS / NIB_PER_CYC,
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic valid_i,
  input  logic last_i,
  output logic ready_o,
  output logic load_o,
  output logic step_o,
  output logic hold_o,
  output logic done_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_q;
  logic             final_step;

  assign ready_o    = (state_q == ST_IDLE);
  assign load_o     = ready_o && valid_i && !clear_i;
  assign step_o     = (state_q == ST_RUN) && !clear_i;
  assign hold_o     = (state_q == ST_HOLD);
  assign final_step = step_o && (cnt_q == CNT_W'(STEPS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      done_o  <= 1'b0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= final_step && last_q;
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          last_q  <= last_i;
        end
        ST_RUN: if (final_step) begin
          state_q <= last_q ? ST_HOLD : ST_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_HOLD: state_q <= ST_HOLD;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crc_word_buf.sv
`timescale 1ns/1ps
module crc_word_buf
  import crc_quad_pkg::*;
#(
  parameter int NIB_PER_CYC = 1,
  localparam int BITS_W = NIB_PER_CYC * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [BITS_W-1:0] bits_o
);
  logic [WORD_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     buf_q <= '0;
    else if (load_i) buf_q <= word_i;
    else if (step_i) buf_q <= buf_q << BITS_W;
  end

  assign bits_o = buf_q[WORD_W-1 -: BITS_W];
endmodule

// File: rtl/crc_quad_engine.sv
`timescale 1ns/1ps
module crc_quad_engine
  import crc_quad_pkg::*;
#(
  parameter int NIB_PER_CYC = 1,
  localparam int BITS_W = NIB_PER_CYC * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ready_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);
  logic              load_w, step_w, hold_w;
  logic [BITS_W-1:0] bits_w;
  logic [CRC_W-1:0]  chk_q, chk_nxt;

  crc_seq_ctrl #(.NIB_PER_CYC(NIB_PER_CYC)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .valid_i (valid_i),
    .last_i  (last_i),
    .ready_o (ready_o),
    .load_o  (load_w),
    .step_o  (step_w),
    .hold_o  (hold_w),
    .done_o  (done_o)
  );

  crc_word_buf #(.NIB_PER_CYC(NIB_PER_CYC)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .step_i (step_w),
    .word_i (word_i),
    .bits_o (bits_w)
  );

  crc_lane #(.NIB_PER_CYC(NIB_PER_CYC)) u_lane (
    .chk_i  (chk_q),
    .bits_i (bits_w),
    .chk_o  (chk_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chk_q <= '0;
    else if (clear_i) chk_q <= '0;
    else if (step_w)  chk_q <= chk_nxt;
  end

  assign crc_o = chk_q;
endmodule

// File: rtl/crc_quad_engine_chk.sv
`timescale 1ns/1ps
module crc_quad_engine_chk
  import crc_quad_pkg::*;
#(
  parameter int NIB_PER_CYC = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             valid_i,
  input logic             ready_o,
  input logic [CRC_W-1:0] crc_o,
  input logic             done_o,
  input logic             hold_w,
  input logic             step_w
);
  // R1
  clear_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_o == '0) && ready_o && !done_o);

  // R4
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !clear_i) |=> !ready_o);

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> hold_w && !ready_o);

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_w && !clear_i) |=> $stable(crc_o) && !ready_o);

  // R8
  clear_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && valid_i) |=> ready_o && !step_w);

  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !clear_i) |=> $stable(crc_o));
endmodule

bind crc_quad_engine crc_quad_engine_chk #(.NIB_PER_CYC(NIB_PER_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clear_i (clear_i),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .crc_o   (crc_o),
  .done_o  (done_o),
  .hold_w  (hold_w),
  .step_w  (step_w)
);

// File: tb/sim_crc_quad_engine.sv
`timescale 1ns/1ps
module sim_crc_quad_engine;
  localparam int NPC   = 1;
  localparam int STEPS = 8 / NPC;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        valid_i = 1'b0;
  logic        last_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        ready_o;
  logic [15:0] crc_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  crc_quad_engine #(.NIB_PER_CYC(NPC)) u0 (
    .clk_i, .rst_ni, .clear_i, .valid_i, .last_i, .word_i,
    .ready_o, .crc_o, .done_o
  );

  function automatic logic [15:0] ref_word(input logic [15:0] c, input logic [31:0] w);
    logic [3:0] s;
    for (int i = 7; i >= 0; i--) begin
      s = c[15:12] ^ w[i*4 +: 4];
      c = {c[11:0], 4'h0} ^ {s, 12'h000} ^ {7'h00, s, 5'h00} ^ {12'h000, s};
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] w, input logic l);
    @(negedge clk_i); word_i = w; last_i = l; valid_i = 1'b1;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i); valid_i = 1'b0; last_i = 1'b0;
  endtask

  // returns at the negedge where ready_o or done_o is first high
  task automatic wait_end(output int cyc);
    cyc = 0;
    while (!ready_o && !done_o && cyc < 100) begin
      cyc++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(crc_o == 16'h0, "R1 crc after reset", crc_o, 0);
    chk(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
    chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
  endtask

  task automatic t_single();
    int cyc;
    pulse_clear();
    push(32'h0000_0001, 1'b1);
    chk(ready_o == 1'b0, "R4 ready low after take", ready_o, 0);
    wait_end(cyc);
    chk(cyc == STEPS, "R4 busy cycles", cyc, STEPS);
    chk(done_o == 1'b1, "R5 done after last word", done_o, 1);
    chk(crc_o == 16'h1021, "R2 single word value", crc_o, 16'h1021);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R5 done is one cycle", done_o, 0);
  endtask

  task automatic t_multi();
    logic [31:0] ws [4] = '{32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000, 32'hDEAD_BEEF};
    logic [15:0] exp = 16'h0;
    int cyc;
    pulse_clear();
    for (int i = 0; i < 4; i++) begin
      push(ws[i], i == 3);
      exp = ref_word(exp, ws[i]);
      wait_end(cyc);
      chk(cyc == STEPS, "R4 busy cycles per word", cyc, STEPS);
      chk(crc_o == exp, "R3 running value", crc_o, exp);
      if (i < 3) begin
        chk(done_o == 1'b0, "R5 no done on inner word", done_o, 0);
        repeat (3) @(negedge clk_i);
        chk(crc_o == exp, "R10 idle value held", crc_o, exp);
      end else begin
        chk(done_o == 1'b1, "R3 done after counted words", done_o, 1);
      end
    end
  endtask

  task automatic t_hold();
    logic [15:0] held;
    int dones = 0;
    held = crc_o;
    @(negedge clk_i); valid_i = 1'b1; word_i = 32'h5555_AAAA; last_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (done_o) dones++;
      chk(ready_o == 1'b0, "R6 ready low in hold", ready_o, 0);
    end
    valid_i = 1'b0; last_i = 1'b0;
    chk(crc_o == held, "R6 value held", crc_o, held);
    chk(dones == 0, "R6 no done in hold", dones, 0);
  endtask

  task automatic t_abort();
    int cyc;
    pulse_clear();
    push(32'hAAAA_AAAA, 1'b1);
    repeat (2) @(negedge clk_i);
    pulse_clear();
    chk(crc_o == 16'h0, "R7 abort zeroes value", crc_o, 0);
    chk(ready_o == 1'b1, "R7 ready after abort", ready_o, 1);
    chk(done_o == 1'b0, "R7 no done after abort", done_o, 0);
    push(32'h0000_0001, 1'b1);
    wait_end(cyc);
    chk(crc_o == 16'h1021, "R7 restart from zero", crc_o, 16'h1021);
  endtask

  task automatic t_clear_accept();
    int dones = 0;
    pulse_clear();
    @(negedge clk_i); clear_i = 1'b1; valid_i = 1'b1; word_i = 32'hFFFF_FFFF; last_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0; valid_i = 1'b0; last_i = 1'b0;
    chk(ready_o == 1'b1, "R8 word not taken", ready_o, 1);
    for (int i = 0; i < STEPS + 3; i++) begin
      @(negedge clk_i);
      if (done_o) dones++;
    end
    chk(dones == 0, "R8 no done from dropped word", dones, 0);
    chk(crc_o == 16'h0, "R8 value untouched", crc_o, 0);
  endtask

  task automatic t_clear_final();
    pulse_clear();
    push(32'h0000_0001, 1'b1);
    // push returns between take edge and first step edge
    repeat (STEPS - 1) @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
    chk(done_o == 1'b0, "R9 no done when cleared at final step", done_o, 0);
    chk(crc_o == 16'h0, "R9 value zero", crc_o, 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 no late done", done_o, 0);
    chk(ready_o == 1'b1, "R9 ready after clear", ready_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_multi();
    t_hold();
    t_abort();
    t_clear_accept();
    t_clear_final();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule